// File: doc/BRIEF.md
# Buffered Return-to-Zero Avionics Word Transmitter

This block takes 32-bit avionics serial words from a 16-bit host bus and sends them on a differential-style pair of logic rails. A host writes each word in two strobed half-words. The block keeps up to eight words in arrival order, fills in bit 32 with parity or a raw data bit, and sends each word as return-to-zero pulses. A "1" bit pulses the ones rail and a "0" bit pulses the zeros rail. A fixed null gap follows every word.

Transmission runs while an enable input is high. The ready output is high only when no word is queued and no word is in its bit phase. Software can use it to tell when a batch has drained. The data rate (10 or 80 master clocks per bit) and the bit-32 policy come in as static control inputs. External line drivers turn the rails into bus voltages.

Top module: `rzt_transmitter`

## Requirements
- R1: After reset, tx_ready is 1, both rails are 0 and the queue is empty.
- R2: A word is loaded by a first-half strobe (half_lo_stb) and then a second-half strobe (half_hi_stb). The first half maps as follows, with word bit 1 sent first:
  - [7:0] carries bits 1..8, with [7] as bit 1.
  - [8] is the raw bit 32.
  - [9] is bit 30 and [10] is bit 31.
  - [15:11] carries bits 9..13, with [11] as bit 9.
  - The second half [15:0] carries bits 14..29, with [0] as bit 14.
  - A second-half strobe with no pending first half is ignored.
- R3: The queue holds 8 words. A completed load that finds the queue full at the start of its cycle is dropped, even if a word leaves in that same cycle.
- R4: tx_ready falls in the cycle after a word is accepted. It returns to 1 once the queue is empty and no word is in its bit phase.
- R5: With tx_enable high and a word queued while idle, the first bit goes active one clock after enable is sampled. That is well within 2.5 bit times. Words leave in load order, bit 1 first.
- R6: At the fast rate, each bit is 5 clocks active and then 5 clocks null. A 1 drives only rail_one and a 0 drives only rail_zero. The two rails are never high together.
- R7: After the null half of bit 32 comes a gap of 4 bit times. At the fast rate, back-to-back words therefore show 45 null clocks between bit 32 and the next bit 1. With slow_rate=1, the same pattern uses 40/40 clocks and a 320-clock gap, which gives 360 null clocks.
- R8: When par_force or par_enable is 1, bit 32 is parity over bits 1..31. It gives odd total parity when par_even is 0 and even total parity when par_even is 1.
- R9: When par_force and par_enable are both 0, bit 32 is the raw bit taken from first-half position [8].
- R10: If tx_enable drops while a word is being sent, both rails are 0 from the next clock. That word is lost, and the next queued word starts from bit 1 when enable returns.
- R11: A load accepted in the same cycle that a word leaves a non-full queue is kept, and it is sent in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_half | input | 16 | Half-word from the host bus |
| half_lo_stb | input | 1 | Captures the first half-word |
| half_hi_stb | input | 1 | Captures the second half-word and queues the word |
| tx_enable | input | 1 | Transmission enable |
| slow_rate | input | 1 | 0: 10 clocks per bit, 1: 80 clocks per bit |
| par_force | input | 1 | 1 forces parity into bit 32 |
| par_enable | input | 1 | With par_force low, 1 selects parity and 0 selects the raw bit |
| par_even | input | 1 | 0: odd parity, 1: even parity |
| rail_one | output | 1 | Ones rail |
| rail_zero | output | 1 | Zeros rail |
| tx_ready | output | 1 | Queue empty and no word in bit phase |

## Verification
A queue load and a queue removal can fall on the same clock edge. This happens when a second-half strobe is sampled exactly at the end of an inter-word gap, while the serializer pulls its next word. The bench finds the first bit of a word on the rails, then counts the 360 clocks of a fast word plus its gap to place the strobe on the pop edge. It does this twice. The first time the queue is full beforehand, so the load must be dropped. The second time the queue has a free slot, so the load must be kept. The scoreboard then shows which word came out after the ninth.

// File: rtl/rzt_pkg.sv
package rzt_pkg;

  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_BITS = 2'd1,
    TX_GAP  = 2'd2
  } tx_state_t;

  // Build the 32-bit word (index k-1 holds serial bit k) from two half-words.
  function automatic logic [WORD_W-1:0] pack_halves(input logic [HALF_W-1:0] first_h,
                                                     input logic [HALF_W-1:0] second_h);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < 8; i++) w[i] = first_h[7-i];
    for (int j = 0; j < 5; j++) w[8+j] = first_h[11+j];
    for (int j = 0; j < HALF_W; j++) w[13+j] = second_h[j];
    w[29] = first_h[9];
    w[30] = first_h[10];
    w[31] = first_h[8];
    return w;
  endfunction

  // Bit-32 policy: parity over the 31-bit body or the raw stored bit.
  function automatic logic fill_bit32(input logic [WORD_W-2:0] body,
                                      input logic raw_bit,
                                      input logic force_par,
                                      input logic par_en,
                                      input logic even_sel);
    logic body_odd;
    body_odd = ^body;
    if (force_par || par_en) return even_sel ? body_odd : ~body_odd;
    return raw_bit;
  endfunction

endpackage

// File: rtl/rzt_loader.sv
module rzt_loader
  import rzt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_in,
  input  logic              lo_stb,
  input  logic              hi_stb,
  output logic              lo_pending,
  output logic              push_req,
  output logic [WORD_W-1:0] push_word
);

  logic [HALF_W-1:0] lo_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_hold    <= '0;
      lo_pending <= 1'b0;
    end else if (lo_stb) begin
      lo_hold    <= half_in;
      lo_pending <= 1'b1;
    end else if (hi_stb) begin
      lo_pending <= 1'b0;
    end
  end

  assign push_req  = hi_stb && lo_pending;
  assign push_word = pack_halves(lo_hold, half_in);

endmodule

// File: rtl/rzt_fifo.sv
module rzt_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_req,
  input  logic [W-1:0]                 push_word,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         empty,
  output logic                         push_ok,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  assign push_ok = push_req && (count != FULL_C);
  assign pop_ok  = pop && (count != '0);
  assign empty   = (count == '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_C);

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_C && push_req && pop) |=> (count == FULL_C - 1'b1));

  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/rzt_serializer.sv
module rzt_serializer
  import rzt_pkg::*;
#(
  parameter int FAST_BIT_CLKS = 10,
  parameter int SLOW_BIT_CLKS = 80,
  parameter int GAP_BITS      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              slow,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] next_word,
  output logic              pop,
  output logic              busy,
  output logic              rail_one,
  output logic              rail_zero
);

  localparam int CNT_MAX = GAP_BITS * SLOW_BIT_CLKS;
  localparam int CNTW    = $clog2(CNT_MAX + 1);
  localparam int IDXW    = $clog2(WORD_W);
  localparam logic [CNTW-1:0] FAST_M1  = CNTW'(FAST_BIT_CLKS - 1);
  localparam logic [CNTW-1:0] SLOW_M1  = CNTW'(SLOW_BIT_CLKS - 1);
  localparam logic [CNTW-1:0] FAST_HF  = CNTW'(FAST_BIT_CLKS / 2);
  localparam logic [CNTW-1:0] SLOW_HF  = CNTW'(SLOW_BIT_CLKS / 2);
  localparam logic [CNTW-1:0] FAST_GM1 = CNTW'(GAP_BITS * FAST_BIT_CLKS - 1);
  localparam logic [CNTW-1:0] SLOW_GM1 = CNTW'(GAP_BITS * SLOW_BIT_CLKS - 1);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(WORD_W - 1);

  tx_state_t         state;
  logic [CNTW-1:0]   cnt;
  logic [IDXW-1:0]   idx;
  logic [WORD_W-1:0] shreg;
  logic [CNTW-1:0]   per_m1, half_len, gap_m1;
  logic              gap_done, bit_done, data_phase, cur_bit;

  assign per_m1   = slow ? SLOW_M1  : FAST_M1;
  assign half_len = slow ? SLOW_HF  : FAST_HF;
  assign gap_m1   = slow ? SLOW_GM1 : FAST_GM1;

  assign gap_done = (state == TX_GAP)  && (cnt == gap_m1);
  assign bit_done = (state == TX_BITS) && (cnt == per_m1);
  assign pop      = tx_en && !fifo_empty && ((state == TX_IDLE) || gap_done);
  assign busy     = (state == TX_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else if (!tx_en) begin
      state <= TX_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else if (pop) begin
      state <= TX_BITS;
      cnt   <= '0;
      idx   <= '0;
      shreg <= next_word;
    end else begin
      case (state)
        TX_BITS: begin
          if (bit_done) begin
            cnt <= '0;
            if (idx == LAST_IDX) state <= TX_GAP;
            else                 idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_GAP: begin
          if (gap_done) begin
            cnt   <= '0;
            state <= TX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt <= '0;
          idx <= '0;
        end
      endcase
    end
  end

  assign cur_bit    = shreg[idx];
  assign data_phase = (state == TX_BITS) && (cnt < half_len);
  assign rail_one   = data_phase && cur_bit;
  assign rail_zero  = data_phase && !cur_bit;

  assert_one_rail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_one && rail_zero));

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!rail_one && !rail_zero));

  assert_gap_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_GAP) |-> (!rail_one && !rail_zero));

endmodule

// File: rtl/rzt_transmitter.sv
module rzt_transmitter
  import rzt_pkg::*;
#(
  parameter int DEPTH         = 8,
  parameter int FAST_BIT_CLKS = 10,
  parameter int SLOW_BIT_CLKS = 80,
  parameter int GAP_BITS      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] host_half,
  input  logic              half_lo_stb,
  input  logic              half_hi_stb,
  input  logic              tx_enable,
  input  logic              slow_rate,
  input  logic              par_force,
  input  logic              par_enable,
  input  logic              par_even,
  output logic              rail_one,
  output logic              rail_zero,
  output logic              tx_ready
);

  localparam int CW = $clog2(DEPTH + 1);

  logic              lo_pending, push_req, push_ok, pop, fifo_empty, busy;
  logic [WORD_W-1:0] push_word, head_raw, head_final;
  logic [CW-1:0]     fifo_count;

  rzt_loader u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_in    (host_half),
    .lo_stb     (half_lo_stb),
    .hi_stb     (half_hi_stb),
    .lo_pending (lo_pending),
    .push_req   (push_req),
    .push_word  (push_word)
  );

  rzt_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .push_word (push_word),
    .pop       (pop),
    .head      (head_raw),
    .empty     (fifo_empty),
    .push_ok   (push_ok),
    .count     (fifo_count)
  );

  assign head_final = {fill_bit32(head_raw[WORD_W-2:0], head_raw[WORD_W-1],
                                  par_force, par_enable, par_even),
                       head_raw[WORD_W-2:0]};

  rzt_serializer #(
    .FAST_BIT_CLKS (FAST_BIT_CLKS),
    .SLOW_BIT_CLKS (SLOW_BIT_CLKS),
    .GAP_BITS      (GAP_BITS)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_enable),
    .slow       (slow_rate),
    .fifo_empty (fifo_empty),
    .next_word  (head_final),
    .pop        (pop),
    .busy       (busy),
    .rail_one   (rail_one),
    .rail_zero  (rail_zero)
  );

  assign tx_ready = fifo_empty && !busy;

  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> !tx_ready);

  assert_orphan_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (half_hi_stb && !lo_pending) |=> (fifo_count <= $past(fifo_count)));

endmodule

// File: tb/rzt_transmitter_tb_top.sv
`timescale 1ns/1ps
module rzt_transmitter_tb_top;

  typedef struct {
    logic [31:0] v;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_half = '0;
  logic        half_lo_stb = 1'b0, half_hi_stb = 1'b0;
  logic        tx_enable = 1'b0, slow_rate = 1'b0;
  logic        par_force = 1'b1, par_enable = 1'b0, par_even = 1'b0;
  logic        rail_one, rail_zero, tx_ready;

  int   n_checks = 0;
  int   n_fails  = 0;
  exp_t exp_q[$];
  int   last_gap = 0;

  always #4 clk = ~clk;

  rzt_transmitter dut_i (
    .clk(clk), .rst_n(rst_n), .host_half(host_half),
    .half_lo_stb(half_lo_stb), .half_hi_stb(half_hi_stb),
    .tx_enable(tx_enable), .slow_rate(slow_rate),
    .par_force(par_force), .par_enable(par_enable), .par_even(par_even),
    .rail_one(rail_one), .rail_zero(rail_zero), .tx_ready(tx_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input logic [15:0] a, input logic [15:0] b,
                                             input bit frc, input bit pen, input bit evn);
    logic [31:0] v;
    int num, ones;
    v = '0;
    for (int p = 0; p < 16; p++) begin
      if (p < 8)       num = 8 - p;
      else if (p == 8) num = 32;
      else if (p == 9) num = 30;
      else if (p == 10) num = 31;
      else             num = p - 2;
      v[num-1]  = a[p];
      v[13+p]   = b[p];
    end
    if (frc || pen) begin
      ones = 0;
      for (int k = 0; k < 31; k++) ones += int'(v[k]);
      v[31] = evn ? (ones % 2 == 1) : (ones % 2 == 0);
    end
    return v;
  endfunction

  // Driver: call just after a negedge; uses two negedges.
  task automatic load_word(input logic [15:0] a, input logic [15:0] b, input bit expect_it, input string tag);
    exp_t e;
    host_half = a; half_lo_stb = 1'b1;
    @(negedge clk);
    half_lo_stb = 1'b0; host_half = b; half_hi_stb = 1'b1;
    if (expect_it) begin
      e.v = model_word(a, b, par_force, par_enable, par_even);
      e.tag = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    half_hi_stb = 1'b0;
  endtask

  task automatic wait_drained(input string req);
    int guard = 0;
    while ((exp_q.size() != 0 || !tx_ready) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    chk(exp_q.size() == 0 && tx_ready, req, {31'd0, tx_ready}, 32'd1);
    repeat (400) @(negedge clk);
  endtask

  // Monitor / scoreboard: samples 2 ns after each rising edge.
  initial begin
    int nbits = 0, high_run = 0, low_run = 0, half;
    bit prev = 0, seen_word = 0, act;
    logic [31:0] cur = '0;
    exp_t e;
    forever begin
      @(posedge clk); #2;
      half = slow_rate ? 40 : 5;
      if (!rst_n || !tx_enable) begin
        nbits = 0; prev = 0; low_run = 0; seen_word = 0;
      end else begin
        act = rail_one | rail_zero;
        if (act && !prev) begin
          if (nbits > 0)
            chk(low_run == half, "R6 null half length", low_run, half);
          else if (seen_word) begin
            last_gap = low_run;
            chk(low_run >= half * 9, "R7 inter-word gap", low_run, half * 9);
          end
          cur[nbits] = rail_one;
          nbits++;
          high_run = 1;
        end else if (act) begin
          high_run++;
        end else if (prev) begin
          chk(high_run == half, "R6 active half length", high_run, half);
          low_run = 1;
          if (nbits == 32) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected word", cur, 32'hx);
            else begin
              e = exp_q.pop_front();
              chk(cur == e.v, {"R5 word order/content ", e.tag}, cur, e.v);
            end
            nbits = 0; seen_word = 1;
          end
        end else begin
          low_run++;
        end
        prev = act;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
    chk(!rail_one && !rail_zero, "R1 rails idle after reset", {rail_one, rail_zero}, 0);

    // R2 orphan second half
    host_half = 16'hFFFF; half_hi_stb = 1'b1;
    @(negedge clk); half_hi_stb = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R2 orphan second half ignored", tx_ready, 1);

    // R4/R5/R7/R8 odd parity, three words
    par_force = 1'b1; par_even = 1'b0;
    load_word(16'hA5C3, 16'h1234, 1, "R8 odd");
    chk(tx_ready == 1'b0, "R4 ready low after load", tx_ready, 0);
    load_word(16'h0F81, 16'hFFFF, 1, "R2 mapping");
    load_word(16'h7E18, 16'h8001, 1, "R8 odd b");
    tx_enable = 1'b1; lat = 0;
    do begin @(negedge clk); lat++; end while (!(rail_one || rail_zero) && lat < 100);
    chk(lat >= 1 && lat <= 25, "R5 start latency", lat, 1);
    wait_drained("R4 ready high after drain");
    chk(last_gap == 45, "R7 fast gap", last_gap, 45);

    // R8 even parity via par_enable, R9 raw bit 32
    tx_enable = 1'b0; @(negedge clk);
    par_force = 1'b0; par_enable = 1'b1; par_even = 1'b1;
    load_word(16'h3C01, 16'h00F0, 1, "R8 even");
    tx_enable = 1'b1;
    wait_drained("R8 drain");
    tx_enable = 1'b0; @(negedge clk);
    par_enable = 1'b0; par_even = 1'b0;
    load_word(16'h0100, 16'h0000, 1, "R9 raw one");
    load_word(16'hFEFF, 16'hFFFF, 1, "R9 raw zero");
    tx_enable = 1'b1;
    wait_drained("R9 drain");

    // R3 overflow: ten loads while idle, eight kept
    tx_enable = 1'b0; @(negedge clk);
    par_force = 1'b1;
    for (int i = 0; i < 10; i++)
      load_word(16'(i * 16'h1111 + 3), 16'(i * 16'h0707), i < 8, "R3 capacity");
    tx_enable = 1'b1;
    wait_drained("R3 drain");

    // R10 enable drop mid-word
    tx_enable = 1'b0; @(negedge clk);
    load_word(16'hDEAD, 16'hBEEF, 1, "R10 lost");
    load_word(16'h1357, 16'h2468, 1, "R10 survivor");
    tx_enable = 1'b1;
    repeat (100) @(negedge clk);
    tx_enable = 1'b0;
    void'(exp_q.pop_front());
    @(negedge clk);
    chk(!rail_one && !rail_zero, "R10 rails quiet after drop", {rail_one, rail_zero}, 0);
    repeat (20) @(negedge clk);
    chk(!rail_one && !rail_zero && !tx_ready, "R10 stays quiet, word queued",
        {rail_one, rail_zero, tx_ready}, 0);
    tx_enable = 1'b1;
    wait_drained("R10 drain");

    // R7 slow rate
    tx_enable = 1'b0; @(negedge clk);
    slow_rate = 1'b1;
    load_word(16'h5A5A, 16'hC33C, 1, "R7 slow a");
    load_word(16'h8001, 16'h7FFE, 1, "R7 slow b");
    tx_enable = 1'b1;
    wait_drained("R7 slow drain");
    chk(last_gap == 360, "R7 slow gap", last_gap, 360);

    // R3/R11 load on the pop edge
    tx_enable = 1'b0; @(negedge clk);
    slow_rate = 1'b0;
    for (int i = 0; i < 8; i++)
      load_word(16'(16'h2000 + i), 16'(16'h0300 + i * 5), 1, "R11 base");
    tx_enable = 1'b1;
    do @(negedge clk); while (!(rail_one || rail_zero));   // N0
    load_word(16'h4449, 16'h0909, 1, "R11 ninth");          // now at N0+2
    host_half = 16'h6A6A; half_lo_stb = 1'b1;
    @(negedge clk); half_lo_stb = 1'b0;                     // N0+3
    repeat (356) @(negedge clk);                            // N0+359
    host_half = 16'h0A0A; half_hi_stb = 1'b1;               // full at pop edge: dropped
    @(negedge clk); half_hi_stb = 1'b0;                     // N0+360
    host_half = 16'h7B7B; half_lo_stb = 1'b1;
    @(negedge clk); half_lo_stb = 1'b0;                     // N0+361
    repeat (358) @(negedge clk);                            // N0+719
    begin
      exp_t e;
      host_half = 16'h0B0B; half_hi_stb = 1'b1;              // push and pop together: kept
      e.v = model_word(16'h7B7B, 16'h0B0B, par_force, par_enable, par_even);
      e.tag = "R11 same-edge push";
      exp_q.push_back(e);
    end
    @(negedge clk); half_hi_stb = 1'b0;
    wait_drained("R11 drain");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule